// File: doc/BRIEF.md
# QPSK Test-Frame Symbol Source

This block produces an endless sequence of fixed-length test frames and delivers them as QPSK symbols, one symbol per accepted handshake. A frame is 200 bits long. It opens with a synchronisation preamble: a length-13 Barker sequence in which every chip is sent twice, so the preamble fills exactly 13 symbols and is never scrambled. The 174 payload bits that follow carry a 15-character ASCII greeting whose last three characters are a decimal frame number, then pseudo-random filler. The whole payload passes through a self-synchronising scrambler before mapping.

Bits are taken two at a time. The first bit of a pair sets the in-phase level and the second sets the quadrature level, each at plus or minus a fixed amplitude. A downstream pulse shaper or test harness pulls symbols with a valid/ready handshake, and a frame marker flags the first preamble symbol of every frame.

Top module: `qpsk_frame_gen`

## Requirements
- R1: A frame is 200 bits (100 symbols). `sym_sof` is high on the first symbol of every frame and low on the other 99.
- R2: Bits 0..25 of a frame are the chips + + + + + - - + + - + - + in that order, each sent twice, with "+" as bit 0 and "-" as bit 1. They are not scrambled, so every preamble symbol has I equal to Q, and the first symbol of a frame is (+d, +d).
- R3: Payload bits 0..104 (frame bits 26..130) are, before scrambling, the text "Hello world " followed by three digit characters, 7 bits per character, most significant bit first.
- R4: The three digits are '0', the tens digit and the units digit of a frame counter. The counter is 0 in the first frame after reset, rises by one per frame, and wraps from 99 to 0.
- R5: The last 69 frame bits (131..199) are, before scrambling, taken from a 9-bit LFSR p that starts at all ones on reset. Each filler bit is b = p[8] xor p[4], after which p becomes {p[7:0], b}. The LFSR moves only on filler bits and keeps its state from one frame to the next.
- R6: Each payload bit is sent as s = raw xor h[13] xor h[14], where h is a 15-bit history of sent payload bits with h[0] the newest. h is all ones at the first payload bit of every frame and takes {h[13:0], s} after each payload bit.
- R7: In each pair, the first bit drives `sym_i` and the second drives `sym_q`. Bit 0 maps to +11585 and bit 1 maps to -11585 (signed 16-bit).
- R8: `sym_valid` is low during reset, goes high on the first clock after reset and stays high. A symbol is taken on a clock edge where `sym_valid` and `sym_ready` are both high. While `sym_ready` is low, `sym_i`, `sym_q` and `sym_sof` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_ready | input | 1 | Consumer accepts the current symbol |
| sym_valid | output | 1 | A symbol is presented |
| sym_i | output | 16 | In-phase level, signed |
| sym_q | output | 16 | Quadrature level, signed |
| sym_sof | output | 1 | Current symbol is the first of a frame |

## Verification
The bit index is the block's key state. If it is off, the preamble pattern or the marker moves away from the 100-symbol grid, and this shows within the first frame. A wrong frame counter first changes the digit symbols near the end of the text, so it appears in the first frame or at the first wrap. A bad scrambler tap or seed, or an LFSR that advances at the wrong time, corrupts the payload symbols from the first affected bit onward. The scrambler's feedback then keeps the error going for the rest of the frame. The bench runs more than 100 frames so the counter wraps, and varies `sym_ready` so that stalls land at every position in the frame.

// File: rtl/qfg_pkg.sv
`timescale 1ns/1ps
package qfg_pkg;
    localparam int FRAME_BITS = 200;
    localparam int BPS        = 2;
    localparam int HDR_CHIPS  = 13;
    localparam int HDR_BITS   = 2 * HDR_CHIPS;
    localparam int CHAR_BITS  = 7;
    localparam int TEXT_CHARS = 15;
    localparam int TEXT_BITS  = CHAR_BITS * TEXT_CHARS;
    localparam int IDX_W      = $clog2(FRAME_BITS + BPS);
    localparam int CNT_W      = 7;
    localparam int CNT_LAST   = 99;
    localparam int SCR_LEN    = 15;
    localparam int SCR_TAP_A  = 13;
    localparam int SCR_TAP_B  = 14;
    localparam int PRBS_LEN   = 9;
    localparam int PRBS_TAP_A = 8;
    localparam int PRBS_TAP_B = 4;
    localparam int CHIP_W     = $clog2(HDR_CHIPS);
    localparam int CHR_W      = $clog2(TEXT_CHARS);

    // chip k at bit k; bit 1 marks a negative chip
    localparam logic [HDR_CHIPS-1:0] PREAMBLE = 13'b0101001100000;

    function automatic logic [CHAR_BITS-1:0] msg_char(input logic [CHR_W-1:0] k,
                                                      input logic [CNT_W-1:0] cnt);
        logic [CHAR_BITS-1:0] c;
        case (k)
            4'd0:    c = 7'h48;
            4'd1:    c = 7'h65;
            4'd2:    c = 7'h6C;
            4'd3:    c = 7'h6C;
            4'd4:    c = 7'h6F;
            4'd5:    c = 7'h20;
            4'd6:    c = 7'h77;
            4'd7:    c = 7'h6F;
            4'd8:    c = 7'h72;
            4'd9:    c = 7'h6C;
            4'd10:   c = 7'h64;
            4'd11:   c = 7'h20;
            4'd13:   c = 7'h30 + (cnt / 7'd10);
            4'd14:   c = 7'h30 + (cnt % 7'd10);
            default: c = 7'h30;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/qfg_bit_lane.sv
`timescale 1ns/1ps
module qfg_bit_lane
    import qfg_pkg::*;
(
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [SCR_LEN-1:0]  scr_i,
    input  logic [PRBS_LEN-1:0] prbs_i,
    output logic                bit_o,
    output logic [SCR_LEN-1:0]  scr_o,
    output logic [PRBS_LEN-1:0] prbs_o
);
    logic [IDX_W-1:0]     pos;
    logic [IDX_W-1:0]     chr;
    logic [IDX_W-1:0]     rem;
    logic [2:0]           bsel;
    logic [CHAR_BITS-1:0] ch;
    logic [CHIP_W-1:0]    chip;
    logic                 raw;
    logic                 fb;

    always_comb begin
        pos    = idx_i - IDX_W'(HDR_BITS);
        chr    = pos / IDX_W'(CHAR_BITS);
        rem    = pos % IDX_W'(CHAR_BITS);
        bsel   = 3'd6 - rem[2:0];
        ch     = msg_char(chr[CHR_W-1:0], cnt_i);
        chip   = idx_i[CHIP_W:1];
        fb     = prbs_i[PRBS_TAP_A] ^ prbs_i[PRBS_TAP_B];
        raw    = 1'b0;
        scr_o  = scr_i;
        prbs_o = prbs_i;
        bit_o  = 1'b0;
        if (idx_i < IDX_W'(HDR_BITS)) begin
            // preamble: clear, and seed the scrambler history for the payload
            bit_o = PREAMBLE[chip];
            scr_o = '1;
        end else begin
            if (pos < IDX_W'(TEXT_BITS)) begin
                raw = ch[bsel];
            end else begin
                raw    = fb;
                prbs_o = {prbs_i[PRBS_LEN-2:0], fb};
            end
            bit_o = raw ^ scr_i[SCR_TAP_A] ^ scr_i[SCR_TAP_B];
            scr_o = {scr_i[SCR_LEN-2:0], bit_o};
        end
    end
endmodule

// File: rtl/qpsk_frame_gen.sv
`timescale 1ns/1ps
module qpsk_frame_gen
    import qfg_pkg::*;
#(
    parameter int                       DATA_W = 16,
    parameter logic signed [DATA_W-1:0] AMP    = 16'sd11585
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_ready,
    output logic                     sym_valid,
    output logic signed [DATA_W-1:0] sym_i,
    output logic signed [DATA_W-1:0] sym_q,
    output logic                     sym_sof
);
    typedef struct packed {
        logic [IDX_W-1:0]          idx;
        logic [CNT_W-1:0]          cnt;
        logic [SCR_LEN-1:0]        scr;
        logic [PRBS_LEN-1:0]       prbs;
        logic                      valid;
        logic                      sof;
        logic signed [DATA_W-1:0]  i;
        logic signed [DATA_W-1:0]  q;
    } gen_state_t;

    gen_state_t st_q, st_d;

    logic [IDX_W-1:0]    lane_idx  [BPS];
    logic [SCR_LEN-1:0]  lane_scr  [BPS+1];
    logic [PRBS_LEN-1:0] lane_prbs [BPS+1];
    logic [BPS-1:0]      lane_bit;

    assign lane_scr[0]  = st_q.scr;
    assign lane_prbs[0] = st_q.prbs;

    // one lane per bit of a symbol, chained so each sees its predecessor's state
    for (genvar k = 0; k < BPS; k++) begin : g_lane
        assign lane_idx[k] = st_q.idx + IDX_W'(k);
        qfg_bit_lane u_lane (
            .idx_i  (lane_idx[k]),
            .cnt_i  (st_q.cnt),
            .scr_i  (lane_scr[k]),
            .prbs_i (lane_prbs[k]),
            .bit_o  (lane_bit[k]),
            .scr_o  (lane_scr[k+1]),
            .prbs_o (lane_prbs[k+1])
        );
    end

    logic             load;
    logic [IDX_W-1:0] idx_step;

    always_comb begin
        st_d     = st_q;
        load     = !st_q.valid || sym_ready;
        idx_step = st_q.idx + IDX_W'(BPS);
        if (load) begin
            st_d.valid = 1'b1;
            st_d.sof   = (st_q.idx == '0);
            st_d.i     = lane_bit[0]     ? -AMP : AMP;
            st_d.q     = lane_bit[BPS-1] ? -AMP : AMP;
            st_d.scr   = lane_scr[BPS];
            st_d.prbs  = lane_prbs[BPS];
            if (idx_step >= IDX_W'(FRAME_BITS)) begin
                st_d.idx = '0;
                st_d.cnt = (st_q.cnt == CNT_W'(CNT_LAST)) ? '0 : st_q.cnt + 1'b1;
            end else begin
                st_d.idx = idx_step;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.cnt   <= '0;
            st_q.scr   <= '1;
            st_q.prbs  <= '1;
            st_q.valid <= 1'b0;
            st_q.sof   <= 1'b0;
            st_q.i     <= '0;
            st_q.q     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sym_valid = st_q.valid;
    assign sym_i     = st_q.i;
    assign sym_q     = st_q.q;
    assign sym_sof   = st_q.sof;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !sym_ready |=> sym_valid && $stable(sym_i) && $stable(sym_q) && $stable(sym_sof)); // R8
    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> sym_valid); // R8
    AST_LEVEL_PM_D: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_i == AMP || sym_i == -AMP) && (sym_q == AMP || sym_q == -AMP)); // R7
    AST_SOF_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_sof |-> sym_i == AMP && sym_q == AMP); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_LAST)); // R4
endmodule

// File: tb/qpsk_frame_gen_tb.sv
`timescale 1ns/1ps
module qpsk_frame_gen_tb;
    localparam int            NFRAMES = 105;
    localparam logic signed [15:0] D  = 16'sd11585;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_ready = 1'b0;
    logic sym_valid;
    logic signed [15:0] sym_i;
    logic signed [15:0] sym_q;
    logic sym_sof;

    always #2.5 clk = ~clk;

    qpsk_frame_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_ready (sym_ready),
        .sym_valid (sym_valid),
        .sym_i     (sym_i),
        .sym_q     (sym_q),
        .sym_sof   (sym_sof)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic       fbits [200];
    logic [8:0] m_lfsr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference frame from the requirement text
    task automatic build_frame(input int f);
        string pre = "+++++--++-+-+";
        string msg;
        logic [14:0] hist;
        logic raw;
        int p = 0;
        msg = $sformatf("Hello world %03d", f % 100);
        for (int c = 0; c < 13; c++) begin
            fbits[p] = (pre[c] == "-"); fbits[p+1] = (pre[c] == "-"); p += 2;
        end
        hist = '1;
        for (int b = 26; b < 200; b++) begin
            if (b < 131) begin
                byte ch = msg[(b-26)/7];
                raw = ch[6 - ((b-26) % 7)];
            end else begin
                raw = m_lfsr[8] ^ m_lfsr[4];
                m_lfsr = {m_lfsr[7:0], raw};
            end
            fbits[b] = raw ^ hist[13] ^ hist[14];
            hist = {hist[13:0], fbits[b]};
        end
    endtask

    function automatic logic signed [15:0] lvl(input logic b);
        return b ? -D : D;
    endfunction

    initial begin
        int frame = 0;
        int sym = 0;
        int stall_run;
        bit prev_held = 0;
        logic signed [15:0] last_i, last_q;
        logic last_sof;
        string tag;
        void'($urandom(32'd1234));
        m_lfsr = '1;
        repeat (4) @(negedge clk);
        chk(sym_valid === 1'b0, "R8", "valid in reset", sym_valid, 0);
        rst_n = 1'b1;
        build_frame(0);
        sym_ready = 1'b0;
        @(negedge clk);
        chk(sym_valid === 1'b1, "R8", "valid after reset", sym_valid, 1);
        stall_run = 0;
        while (frame < NFRAMES) begin
            if (sym < 13)       tag = "R2";
            else if (sym < 65)  tag = "R3 R4 R6";
            else                tag = "R5 R6";
            chk(sym_valid === 1'b1, "R8", "valid stays high", sym_valid, 1);
            chk(sym_i === lvl(fbits[2*sym]), {tag, " R7"},
                $sformatf("I frame %0d sym %0d", frame, sym), sym_i, lvl(fbits[2*sym]));
            chk(sym_q === lvl(fbits[2*sym+1]), {tag, " R7"},
                $sformatf("Q frame %0d sym %0d", frame, sym), sym_q, lvl(fbits[2*sym+1]));
            chk(sym_sof === (sym == 0), "R1",
                $sformatf("sof frame %0d sym %0d", frame, sym), sym_sof, (sym == 0));
            if (prev_held)
                chk(sym_i === last_i && sym_q === last_q && sym_sof === last_sof, "R8",
                    "hold during stall", sym_i, last_i);
            last_i = sym_i; last_q = sym_q; last_sof = sym_sof;
            // ready pattern: full rate, long stalls, then random
            if (frame < 2)        sym_ready = 1'b1;
            else if (frame < 5)   sym_ready = ($urandom % 4) == 0;
            else if (stall_run > 0) begin sym_ready = 1'b0; stall_run--; end
            else begin
                sym_ready = ($urandom % 2) == 1;
                if (($urandom % 50) == 0) stall_run = 8;
            end
            prev_held = !sym_ready;
            if (sym_ready) begin
                sym++;
                if (sym == 100) begin
                    sym = 0; frame++;
                    if (frame < NFRAMES) build_frame(frame);
                end
            end
            @(negedge clk);
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule